// File: doc/BRIEF.md
# Two-Wire Bus Slave Command Front End

This block is the slave side of a two-wire serial bus for a dual digital potentiometer controller. It works entirely in the system clock domain and oversamples the raw clock line and data line. It detects start and stop conditions and assembles bytes most significant bit first. It checks the address byte against a fixed device-type nibble and a 4-bit strap, and it acknowledges each accepted byte by pulling the data line low during the ninth clock.

After the address byte, the front end hands the instruction byte to a command engine. The opcode nibble then selects what follows. A short command ends after its acknowledge. A write command accepts one more byte, which goes to the engine. A read command shifts one byte supplied by the engine back to the host. The step command turns every following clock pulse into a wiper step until a stop. While the engine reports that a nonvolatile write is in progress, the address byte is left unacknowledged, so the host can poll for completion.

Top module: `tw_cmd_frontend`

## Requirements
- R1: After reset, and after any stop condition (data rising while clock is high), the data line is released and no event is produced until a new start (data falling while clock is high).
- R2: An address byte whose upper nibble is 0101 and whose lower nibble equals `strap_i` is acknowledged. The acknowledge drives `sda_pull_o` high from the fall of the eighth clock to the fall of the ninth, and the pull level only changes while the clock is low.
- R3: A mismatched address byte is not acknowledged. Every later byte up to the next start is also left unacknowledged and produces no event.
- R4: If `busy_i` is high when a matching address byte completes, that byte is not acknowledged. The same address is acknowledged again once `busy_i` is low.
- R5: The byte after an acknowledged address is always acknowledged and reported once on `instr_o` with a one-cycle `instr_valid_o` pulse. Its bits 7..4 are the opcode.
- R6: For opcodes 1010 and 1100, the third byte is acknowledged and reported once on `wr_data_o` with a one-cycle `wr_valid_o` pulse.
- R7: For opcodes 1001 and 1011, the slave shifts out `rd_data_i` MSB first, with the first bit appearing after the instruction acknowledge. It keeps the data line released during the ninth clock of that byte.
- R8: For opcode 0010, each following completed clock high pulse yields one `step_valid_o` pulse. `step_up_o` is 1 when the data line was high and 0 when it was low. The clock rise that precedes a stop yields no step.
- R9: For any other opcode, the command ends after the instruction acknowledge: further bytes are neither acknowledged nor reported.
- R10: A start condition in the middle of a byte abandons the current command and begins a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| strap_i | input | 4 | Board-strapped low address nibble |
| busy_i | input | 1 | Engine nonvolatile write in progress |
| rd_data_i | input | 8 | Byte returned to the host on read commands |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| instr_valid_o | output | 1 | One-cycle pulse: instruction byte received |
| instr_o | output | 8 | Received instruction byte |
| wr_valid_o | output | 1 | One-cycle pulse: write data byte received |
| wr_data_o | output | 8 | Received write data byte |
| step_valid_o | output | 1 | One-cycle pulse: one wiper step |
| step_up_o | output | 1 | Step direction, 1 toward the high terminal |

## Verification
In step mode, both step emission and stop detection follow a clock high pulse. The last step before a stop is sent with the data line low, which is exactly the level the stop sequence then raises. The scoreboard must hold exactly the listed steps and nothing for the stop's clock rise. A start can also arrive while the bit counter sits mid-byte. It is provoked by breaking off after four address bits. It is judged by the acknowledge of the next full address and by the instruction event that follows.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
// Shared widths, state and command-class types for the two-wire front end.
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_IGNORE
    } fe_state_e;

    typedef enum logic [1:0] {CL_SHORT, CL_WRITE, CL_READ, CL_STEP} cmd_class_e;

    localparam logic [NIB_W-1:0] OP_RD_WIPER = 4'b1001;
    localparam logic [NIB_W-1:0] OP_WR_WIPER = 4'b1010;
    localparam logic [NIB_W-1:0] OP_RD_REG   = 4'b1011;
    localparam logic [NIB_W-1:0] OP_WR_REG   = 4'b1100;
    localparam logic [NIB_W-1:0] OP_STEP     = 4'b0010;

    // Map an opcode nibble to the framing that follows its acknowledge.
    function automatic cmd_class_e classify_op(input logic [NIB_W-1:0] op);
        case (op)
            OP_RD_WIPER, OP_RD_REG: return CL_READ;
            OP_WR_WIPER, OP_WR_REG: return CL_WRITE;
            OP_STEP:                return CL_STEP;
            default:                return CL_SHORT;
        endcase
    endfunction
endpackage

// File: rtl/tw_bus_sync.sv
`timescale 1ns/1ps
// Synchronizes the raw clock and data lines and derives bus events.
// Assumes bus lines idle high; STAGES >= 2. Events are one-cycle pulses.
module tw_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PW = 2 * STAGES;

    logic [PW-1:0] pipe;
    logic [1:0]    prev;

    // Shift both lines through the synchronizer and keep the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
            prev <= 2'b11;
        end else begin
            pipe <= {pipe[PW-3:0], scl_i, sda_i};
            prev <= pipe[PW-1 -: 2];
        end
    end

    assign scl_lvl   = pipe[PW-1];
    assign sda_lvl   = pipe[PW-2];
    assign scl_rise  = scl_lvl & ~prev[1];
    assign scl_fall  = ~scl_lvl & prev[1];
    assign start_det = scl_lvl & prev[1] & prev[0] & ~sda_lvl;
    assign stop_det  = scl_lvl & prev[1] & ~prev[0] & sda_lvl;
endmodule

// File: rtl/tw_bit_shifter.sv
`timescale 1ns/1ps
// Bit counter and shift register shared by receive and transmit.
// Counts clock rises up to the ninth; shifts in on rises when receiving,
// shifts out on falls when transmitting. clr restarts the byte.
module tw_bit_shifter
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              sda_lvl,
    input  logic              tx_mode,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_next
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [BYTE_W-1:0] data_q;

    // Advance the bit position and move data in or out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            data_q  <= '0;
        end else if (clr) begin
            bit_cnt <= '0;
            if (load) data_q <= load_data;
        end else if (rise) begin
            if (bit_cnt <= LAST_CNT) bit_cnt <= bit_cnt + ONE;
            if (!tx_mode && bit_cnt < LAST_CNT) data_q <= {data_q[BYTE_W-2:0], sda_lvl};
        end else if (fall && tx_mode && bit_cnt >= ONE && bit_cnt < LAST_CNT) begin
            data_q <= {data_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign rx_byte = {data_q[BYTE_W-2:0], sda_lvl};
    assign tx_next = data_q[BYTE_W-2];
endmodule

// File: rtl/tw_frame_ctrl.sv
`timescale 1ns/1ps
// Command framing state machine: address check, acknowledge, instruction
// hand-off, write data, read transmit and step forwarding.
// Assumes bus events come from tw_bus_sync and bit positions from tw_bit_shifter.
module tw_frame_ctrl
    import tw_pkg::*;
#(
    parameter logic [NIB_W-1:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [NIB_W-1:0]  strap,
    input  logic              busy,
    input  logic              rd_msb,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_next,
    output logic              clr,
    output logic              load,
    output logic              tx_mode,
    output fe_state_e         state,
    output logic              sda_pull,
    output logic              instr_valid,
    output logic [BYTE_W-1:0] instr_q,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    output logic              step_valid,
    output logic              step_up
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    logic       ack_pend;
    logic       byte_end;
    cmd_class_e cls;

    assign cls      = classify_op(instr_q[BYTE_W-1 -: NIB_W]);
    assign byte_end = scl_fall && (bit_cnt == ACK_DONE);
    assign clr      = start_det | stop_det | byte_end;
    assign load     = byte_end && (state == ST_INSTR) && (cls == CL_READ);
    assign tx_mode  = (state == ST_RDATA);

    // Main framing sequencer with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            sda_pull    <= 1'b0;
            ack_pend    <= 1'b0;
            instr_valid <= 1'b0;
            instr_q     <= '0;
            wr_valid    <= 1'b0;
            wr_data     <= '0;
            step_valid  <= 1'b0;
            step_up     <= 1'b0;
        end else begin
            instr_valid <= 1'b0;
            wr_valid    <= 1'b0;
            step_valid  <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                sda_pull <= 1'b0;
                ack_pend <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                ack_pend <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INSTR, ST_WDATA: begin
                        if (scl_rise && bit_cnt == LAST_BIT) begin
                            if (state == ST_ADDR) begin
                                ack_pend <= (rx_byte == {DEV_TYPE, strap}) && !busy;
                            end else if (state == ST_INSTR) begin
                                ack_pend    <= 1'b1;
                                instr_q     <= rx_byte;
                                instr_valid <= 1'b1;
                            end else begin
                                ack_pend <= 1'b1;
                                wr_data  <= rx_byte;
                                wr_valid <= 1'b1;
                            end
                        end
                        if (scl_fall && bit_cnt == ACK_SLOT) begin
                            if (ack_pend) sda_pull <= 1'b1;
                            else          state    <= ST_IGNORE;
                        end
                        if (byte_end) begin
                            sda_pull <= 1'b0;
                            ack_pend <= 1'b0;
                            if (state == ST_ADDR) begin
                                state <= ST_INSTR;
                            end else if (state == ST_WDATA) begin
                                state <= ST_IGNORE;
                            end else begin
                                case (cls)
                                    CL_READ: begin
                                        state    <= ST_RDATA;
                                        sda_pull <= ~rd_msb;
                                    end
                                    CL_WRITE: state <= ST_WDATA;
                                    CL_STEP:  state <= ST_STEP;
                                    default:  state <= ST_IGNORE;
                                endcase
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == ACK_DONE)      state    <= ST_IGNORE;
                            else if (bit_cnt == ACK_SLOT) sda_pull <= 1'b0;
                            else if (bit_cnt != '0)       sda_pull <= ~tx_next;
                        end
                    end
                    ST_STEP: begin
                        if (scl_fall) begin
                            step_valid <= 1'b1;
                            step_up    <= sda_lvl;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_cmd_frontend.sv
`timescale 1ns/1ps
// Top of the two-wire slave command front end: synchronizer, bit shifter
// and framing controller. Open-drain output: sda_pull_o=1 drives the line low.
module tw_cmd_frontend
    import tw_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [NIB_W-1:0] DEV_TYPE    = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [NIB_W-1:0]  strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              instr_valid_o,
    output logic [BYTE_W-1:0] instr_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              step_valid_o,
    output logic              step_up_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              clr, load, tx_mode, tx_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_byte;
    fe_state_e         state;

    tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    tw_bit_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_data(rd_data_i),
        .rise(scl_rise), .fall(scl_fall), .sda_lvl(sda_lvl), .tx_mode(tx_mode),
        .bit_cnt(bit_cnt), .rx_byte(rx_byte), .tx_next(tx_next)
    );

    tw_frame_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap(strap_i), .busy(busy_i), .rd_msb(rd_data_i[BYTE_W-1]),
        .bit_cnt(bit_cnt), .rx_byte(rx_byte), .tx_next(tx_next),
        .clr(clr), .load(load), .tx_mode(tx_mode), .state(state),
        .sda_pull(sda_pull_o), .instr_valid(instr_valid_o), .instr_q(instr_o),
        .wr_valid(wr_valid_o), .wr_data(wr_data_o),
        .step_valid(step_valid_o), .step_up(step_up_o)
    );
endmodule

// File: rtl/tw_cmd_frontend_chk.sv
`timescale 1ns/1ps
// Protocol checker bound into tw_cmd_frontend; observes synchronized bus
// events, framing state and the outputs.
module tw_cmd_frontend_chk
    import tw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_lvl,
    input logic      start_det,
    input logic      stop_det,
    input fe_state_e state,
    input logic      sda_pull_o,
    input logic      instr_valid_o,
    input logic      wr_valid_o,
    input logic      step_valid_o
);
    // R1: a stop always leaves the line released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    // R2: pull level changes only while the clock was low, except on start/stop
    p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl));

    // R3: the ignore state never drives the line nor reports
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_pull_o && !instr_valid_o && !wr_valid_o && !step_valid_o));

    // R5: instruction handed over on a clock rise, events never overlap
    p_instr_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_o |-> scl_lvl);
    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_valid_o, wr_valid_o, step_valid_o}));

    // R8: steps follow the end of a clock high pulse
    p_step_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_o |-> !scl_lvl);

    // R10: a start restarts address reception with the line released
    p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && !sda_pull_o));
endmodule

bind tw_cmd_frontend tw_cmd_frontend_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
    .stop_det(stop_det), .state(state), .sda_pull_o(sda_pull_o),
    .instr_valid_o(instr_valid_o), .wr_valid_o(wr_valid_o),
    .step_valid_o(step_valid_o)
);

// File: tb/tw_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module tw_cmd_frontend_tb_top;
    localparam int QW = 6;
    localparam int HW = 12;
    localparam logic [1:0] K_INSTR = 2'd1, K_WR = 2'd2, K_STEP = 2'd3;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] data;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n, scl_m, sda_m, busy;
    logic [3:0] strap;
    logic [7:0] rd_data;
    logic       sda_pull, instr_valid, wr_valid, step_valid, step_up;
    logic [7:0] instr_b, wr_b;
    logic       sda_bus;

    int    n_checks = 0;
    int    n_fail   = 0;
    ev_t   exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;

    tw_cmd_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
        .sda_pull_o(sda_pull), .instr_valid_o(instr_valid), .instr_o(instr_b),
        .wr_valid_o(wr_valid), .wr_data_o(wr_b),
        .step_valid_o(step_valid), .step_up_o(step_up)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [1:0] k, input logic [7:0] d, input string req);
        ev_t e;
        e.kind = k;
        e.data = d;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    // Monitor: pop expected events and compare as the design produces them.
    always @(negedge clk) begin
        ev_t   got, e;
        string t;
        if (rst_n && (instr_valid || wr_valid || step_valid)) begin
            got.kind = instr_valid ? K_INSTR : (wr_valid ? K_WR : K_STEP);
            got.data = instr_valid ? instr_b : (wr_valid ? wr_b : {7'b0, step_up});
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R9 unexpected event", int'(got), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == e, t, int'(got), int'(e));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(QW);
        scl_m = 1'b1; wait_clk(HW);
        sda_m = 1'b0; wait_clk(HW);
        scl_m = 1'b0; wait_clk(QW);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(QW);
        scl_m = 1'b1; wait_clk(HW);
        sda_m = 1'b1; wait_clk(HW);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = v[7-i]; wait_clk(QW);
            scl_m = 1'b1;   wait_clk(HW);
            scl_m = 1'b0;   wait_clk(QW);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        send_bits(v, 8);
        sda_m = 1'b1; wait_clk(QW);
        scl_m = 1'b1; wait_clk(HW / 2);
        acked = !sda_bus;
        wait_clk(HW / 2);
        scl_m = 1'b0; wait_clk(QW);
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] v, output bit rel9);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clk(QW);
            scl_m = 1'b1; wait_clk(HW / 2);
            v[7-i] = sda_bus;
            wait_clk(HW / 2);
            scl_m = 1'b0;
        end
        wait_clk(QW);
        rel9 = !sda_pull;
        sda_m = m_ack ? 1'b0 : 1'b1; wait_clk(QW);
        scl_m = 1'b1; wait_clk(HW / 2);
        rel9 = rel9 && !sda_pull;
        wait_clk(HW / 2);
        scl_m = 1'b0; wait_clk(QW);
        sda_m = 1'b1;
    endtask

    task automatic step_pulse(input bit up);
        sda_m = up;   wait_clk(QW);
        scl_m = 1'b1; wait_clk(HW);
        scl_m = 1'b0; wait_clk(QW);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit         ack, rel;
        logic [7:0] rb;
        logic [7:0] addr;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0;
        strap = 4'hA; rd_data = 8'h00;
        addr  = {4'b0101, 4'hA};
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: reset state
        check(sda_pull == 1'b0, "R1 reset release", sda_pull, 0);
        check({instr_valid, wr_valid, step_valid} == 3'b0, "R1 reset no event",
              {instr_valid, wr_valid, step_valid}, 0);

        // Write command: address, instruction, data
        bus_start();
        send_byte(addr, ack);
        check(ack, "R2 address ack", ack, 1);
        expect_ev(K_INSTR, 8'hA4, "R5 instruction byte");
        send_byte(8'hA4, ack);
        check(ack, "R5 instruction ack", ack, 1);
        expect_ev(K_WR, 8'h2B, "R6 write data");
        send_byte(8'h2B, ack);
        check(ack, "R6 data ack", ack, 1);
        bus_stop();
        check(sda_pull == 1'b0, "R1 released after stop", sda_pull, 0);

        // Wrong device type, then a further byte
        bus_start();
        send_byte(8'h6A, ack);
        check(!ack, "R3 type mismatch nack", ack, 0);
        send_byte(8'hA4, ack);
        check(!ack, "R3 later byte ignored", ack, 0);
        bus_stop();

        // Wrong strap
        bus_start();
        send_byte(8'h53, ack);
        check(!ack, "R3 strap mismatch nack", ack, 0);
        bus_stop();

        // Busy engine: polled address refused, then accepted
        busy = 1'b1;
        bus_start();
        send_byte(addr, ack);
        check(!ack, "R4 busy nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(addr, ack);
        check(ack, "R4 ack after busy", ack, 1);
        expect_ev(K_INSTR, 8'hD6, "R9 short instruction");
        send_byte(8'hD6, ack);
        check(ack, "R9 short instruction ack", ack, 1);
        send_byte(8'h77, ack);
        check(!ack, "R9 extra byte nack", ack, 0);
        bus_stop();

        // Read commands
        rd_data = 8'h35;
        bus_start();
        send_byte(addr, ack);
        expect_ev(K_INSTR, 8'hB1, "R5 read instruction");
        send_byte(8'hB1, ack);
        check(ack, "R7 read instruction ack", ack, 1);
        recv_byte(1'b0, rb, rel);
        check(rb == 8'h35, "R7 read data", rb, 8'h35);
        check(rel, "R7 released on ninth clock", rel, 1);
        bus_stop();

        rd_data = 8'hC6;
        bus_start();
        send_byte(addr, ack);
        expect_ev(K_INSTR, 8'h94, "R5 wiper read instruction");
        send_byte(8'h94, ack);
        recv_byte(1'b1, rb, rel);
        check(rb == 8'hC6, "R7 wiper read data", rb, 8'hC6);
        check(rel, "R7 released with master ack", rel, 1);
        bus_stop();

        // Step mode; final step is low so the stop clock is a pending hazard
        bus_start();
        send_byte(addr, ack);
        expect_ev(K_INSTR, 8'h24, "R8 step instruction");
        send_byte(8'h24, ack);
        check(ack, "R8 step instruction ack", ack, 1);
        expect_ev(K_STEP, 8'h01, "R8 step up 1");
        step_pulse(1'b1);
        expect_ev(K_STEP, 8'h01, "R8 step up 2");
        step_pulse(1'b1);
        expect_ev(K_STEP, 8'h00, "R8 step down 1");
        step_pulse(1'b0);
        expect_ev(K_STEP, 8'h01, "R8 step up 3");
        step_pulse(1'b1);
        expect_ev(K_STEP, 8'h00, "R8 step down 2");
        step_pulse(1'b0);
        bus_stop();
        wait_clk(20);
        check(exp_q.size() == 0, "R8 step count", exp_q.size(), 0);

        // Repeated start in the middle of the address byte
        bus_start();
        send_bits(addr, 4);
        bus_start();
        send_byte(addr, ack);
        check(ack, "R10 address after restart", ack, 1);
        expect_ev(K_INSTR, 8'hE5, "R10 instruction after restart");
        send_byte(8'hE5, ack);
        check(ack, "R10 instruction ack", ack, 1);
        bus_stop();

        wait_clk(20);
        check(exp_q.size() == 0, "R5 all events seen", exp_q.size(), 0);
        finish_run();
    end
endmodule